// File: doc/BRIEF.md
# Reset Controller with Power-On Status Flag

This block merges two reset causes into one active-high core reset. The first is an external active-low reset pin. The second is a power-on condition, signalled by a synchronous "supply good" level that an analog detector outside the block provides. The pin passes through a two-stage synchroniser and a minimum-width filter, so a short glitch cannot reset the chip. The supply input drives a stabilisation timer that keeps the core in reset until the supply has stayed good for a programmable number of cycles.

The core reset is raised combinationally as soon as an accepted cause is present. It is lowered only at a clock edge. A one-bit power-on status flag records that a supply-driven reset took place. Software cannot clear it. Only an accepted pin reset returns it to zero. Software reads the flag through a small capture-on-read port.

The power-on path is only active while the synchronised pin is high. When both causes are present, the pin reset wins.

Top module: `rst_ctrl`

## Requirements
- R1: When the pin is driven low after a clock edge and kept low, `core_rst` reads 1 from the sample that follows the (PIN_MIN_CYC+1)-th rising edge. It stays 1 for as long as the pin stays low.
- R2: A low pulse on the pin that lasts fewer than PIN_MIN_CYC cycles, while the supply is good, never raises `core_rst` and leaves the status flag unchanged.
- R3: The supply stays good and a pin reset has been accepted. Once the pin returns high after a clock edge, `core_rst` reads 0 after the third following rising edge.
- R4: The synchronised pin is high and `supply_good` goes low. `core_rst` then rises in the same cycle, without waiting for a clock edge.
- R5: After `supply_good` returns high, `core_rst` stays 1 until STAB_CYC consecutive rising edges have seen the supply good. It reads 0 after the STAB_CYC-th edge.
- R6: A dip of `supply_good` during the stabilisation count restarts the count from zero. The full STAB_CYC cycles are needed after the last rise.
- R7: Every power-on condition (pin high, supply low) sets the status flag to 1. This includes a new one that follows a pin reset.
- R8: An accepted pin reset clears the status flag to 0 and takes priority over a power-on condition. The flag stays 0 until the synchronised pin is high again while the supply is low.
- R9: Asserting `stat_rd_en` at a clock edge loads `stat_rd_data` with the flag in bit 0 and zero in every other bit. This makes the expected read value exactly 1 or 0. While `stat_rd_en` is low, `stat_rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to `clk` |
| supply_good | input | 1 | Supply above threshold, already synchronous to `clk` |
| core_rst | output | 1 | Internal reset, active high |
| stat_rd_en | input | 1 | Capture the status flag into the read register |
| stat_rd_data | output | RD_W | Read register; bit 0 is the power-on flag |

## Verification
The checker assumes that `supply_good` changes only once per clock period and is already synchronous. It also assumes that the pin holds each level for whole cycles. Under those assumptions a rise of `core_rst` can be traced to a low supply or to a long enough low run on the pin. The bench drives every input one nanosecond after a rising edge and keeps the pin at one level for whole periods. It sweeps pulse widths across the filter boundary and places supply dips at every position of the stabilisation count. It waits for the assertions to settle a few cycles after start-up before relying on them.

// File: rtl/rst_ctrl_pkg.sv
// Package: shared helpers for the reset controller.
// Assumes: counts passed in are at least 1.
package rst_ctrl_pkg;

    // Width needed to hold values 0..n inclusive.
    function automatic int cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rst_ctrl_pin_filt.sv
// Module: synchronises the external reset pin and accepts it only after
// PIN_MIN consecutive low samples.
// Assumes: pin is asynchronous; clk is free running. The synchronised pin
// level acts as the synchronous active-low reset of the width counter.
module rst_ctrl_pin_filt
    import rst_ctrl_pkg::*;
#(
    parameter int PIN_MIN = 20
) (
    input  logic clk,
    input  logic pin_n,
    output logic pin_hi,
    output logic pin_take,
    output logic pin_hold
);
    localparam int CW  = cnt_w(PIN_MIN);
    localparam int LIM = PIN_MIN - 1;

    logic          meta_q;
    logic          sync_q;
    logic [CW-1:0] low_cnt;
    logic          hold_q;

    // Two-stage synchroniser for the asynchronous pin.
    always_ff @(posedge clk) begin
        meta_q <= pin_n;
        sync_q <= meta_q;
    end

    // Count consecutive low samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (sync_q)
            low_cnt <= '0;
        else if (low_cnt != LIM[CW-1:0])
            low_cnt <= low_cnt + 1'b1;
    end

    // Keep the accepted pin reset until the synchronised pin returns high.
    always_ff @(posedge clk) begin
        if (sync_q)
            hold_q <= 1'b0;
        else if (pin_take)
            hold_q <= 1'b1;
    end

    assign pin_hi   = sync_q;
    assign pin_take = !sync_q && (low_cnt == LIM[CW-1:0]);
    assign pin_hold = hold_q;
endmodule

// File: rtl/rst_ctrl_por_seq.sv
// Module: power-on reset sequencer with a stabilisation timer.
// Assumes: supply_ok is synchronous to clk; pin_take has priority.
module rst_ctrl_por_seq
    import rst_ctrl_pkg::*;
#(
    parameter int STAB = 1000
) (
    input  logic clk,
    input  logic pin_hi,
    input  logic supply_ok,
    input  logic pin_take,
    output logic por_take,
    output logic por_hold
);
    localparam int CW  = cnt_w(STAB);
    localparam int LIM = STAB - 1;

    logic          act_q;
    logic [CW-1:0] stab_cnt;

    assign por_take = pin_hi && !supply_ok;

    // Track the power-on state and count the stable-supply cycles.
    always_ff @(posedge clk) begin
        if (pin_take) begin
            act_q    <= 1'b0;
            stab_cnt <= '0;
        end else if (por_take) begin
            act_q    <= 1'b1;
            stab_cnt <= '0;
        end else if (act_q) begin
            if (!supply_ok) begin
                stab_cnt <= '0;
            end else if (stab_cnt == LIM[CW-1:0]) begin
                act_q    <= 1'b0;
                stab_cnt <= '0;
            end else begin
                stab_cnt <= stab_cnt + 1'b1;
            end
        end
    end

    assign por_hold = act_q;
endmodule

// File: rtl/rst_ctrl_flag_reg.sv
// Module: power-on status flag and its capture-on-read port.
// Assumes: pin_take and por_take are never both high (they need opposite
// levels of the synchronised pin); pin_take is still checked first.
module rst_ctrl_flag_reg #(
    parameter int RD_W = 8
) (
    input  logic            clk,
    input  logic            por_take,
    input  logic            pin_take,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data
);
    logic flag_q;

    // Set on a power-on condition, cleared only by an accepted pin reset.
    always_ff @(posedge clk) begin
        if (pin_take)
            flag_q <= 1'b0;
        else if (por_take)
            flag_q <= 1'b1;
    end

    // Capture the flag into the read register on request.
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_data <= {{(RD_W-1){1'b0}}, flag_q};
    end
endmodule

// File: rtl/rst_ctrl.sv
// Module: reset controller top. Combines a filtered pin reset with a
// power-on reset and exposes a read-only power-on flag.
// Assumes: supply_good is synchronous; ext_rst_n may be asynchronous.
// Reset rises combinationally and falls only on a clock edge.
module rst_ctrl #(
    parameter int PIN_MIN_CYC = 20,
    parameter int STAB_CYC    = 1000,
    parameter int RD_W        = 8
) (
    input  logic            clk,
    input  logic            ext_rst_n,
    input  logic            supply_good,
    output logic            core_rst,
    input  logic            stat_rd_en,
    output logic [RD_W-1:0] stat_rd_data
);
    logic pin_hi;
    logic pin_take;
    logic pin_hold;
    logic por_take;
    logic por_hold;

    rst_ctrl_pin_filt #(.PIN_MIN(PIN_MIN_CYC)) u_pin (
        .clk      (clk),
        .pin_n    (ext_rst_n),
        .pin_hi   (pin_hi),
        .pin_take (pin_take),
        .pin_hold (pin_hold)
    );

    rst_ctrl_por_seq #(.STAB(STAB_CYC)) u_por (
        .clk       (clk),
        .pin_hi    (pin_hi),
        .supply_ok (supply_good),
        .pin_take  (pin_take),
        .por_take  (por_take),
        .por_hold  (por_hold)
    );

    rst_ctrl_flag_reg #(.RD_W(RD_W)) u_flag (
        .clk      (clk),
        .por_take (por_take),
        .pin_take (pin_take),
        .rd_en    (stat_rd_en),
        .rd_data  (stat_rd_data)
    );

    // Raise at once on any accepted cause; fall when both held states clear.
    assign core_rst = pin_take | pin_hold | por_take | por_hold;
endmodule

// File: rtl/rst_ctrl_chk.sv
// Module: property checker for rst_ctrl, bound to every instance.
// Assumes: inputs change once per cycle; STAB_CYC >= 2.
module rst_ctrl_chk #(
    parameter int PIN_MIN_CYC = 20,
    parameter int RD_W        = 8
) (
    input logic            clk,
    input logic            ext_rst_n,
    input logic            supply_good,
    input logic            core_rst,
    input logic            stat_rd_en,
    input logic [RD_W-1:0] stat_rd_data
);
    localparam int RUN_MAX = PIN_MIN_CYC + 2;
    localparam int RW      = $clog2(RUN_MAX + 1);

    logic [2:0]    age_q = '0;
    logic          settled;
    logic [RW-1:0] low_run;
    logic [RW-1:0] last_run;

    // Age counter that enables the properties a few cycles after start.
    always_ff @(posedge clk) begin
        if (age_q != 3'd7)
            age_q <= age_q + 3'd1;
    end
    assign settled = (age_q >= 3'd4);

    // Measure the current low run of the pin and remember the last one.
    always_ff @(posedge clk) begin
        if (ext_rst_n) begin
            if (low_run != '0)
                last_run <= low_run;
            low_run <= '0;
        end else if (low_run != RUN_MAX[RW-1:0]) begin
            low_run <= low_run + 1'b1;
        end
    end

    // R4
    por_assert_chk: assert property (@(posedge clk) disable iff (!settled)
        (ext_rst_n && $past(ext_rst_n) && $past(ext_rst_n, 2) && !supply_good)
        |-> core_rst);

    // R5
    stab_release_chk: assert property (@(posedge clk) disable iff (!settled)
        $fell(core_rst) |-> (supply_good && $past(supply_good)));

    // R2
    pulse_filter_chk: assert property (@(posedge clk) disable iff (!settled)
        $rose(core_rst) |-> (!supply_good || low_run >= PIN_MIN_CYC[RW-1:0]
                             || last_run >= PIN_MIN_CYC[RW-1:0]));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!settled)
        ($past(ext_rst_n) && $past(ext_rst_n, 2) && $past(ext_rst_n, 3)
         && $past(!supply_good) && stat_rd_en) |=> stat_rd_data[0]);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!settled)
        (low_run >= RUN_MAX[RW-1:0] && stat_rd_en) |=> !stat_rd_data[0]);

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!settled)
        !$past(stat_rd_en) |-> $stable(stat_rd_data));
endmodule

bind rst_ctrl rst_ctrl_chk #(.PIN_MIN_CYC(PIN_MIN_CYC), .RD_W(RD_W)) u_chk (.*);

// File: tb/test_rst_ctrl.sv
// Bench: sweeps pulse widths and supply-dip positions on a small configuration.
module test_rst_ctrl;
    localparam int P = 6;
    localparam int S = 12;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         ext_rst_n = 1'b1;
    logic         supply_good = 1'b0;
    logic         stat_rd_en = 1'b0;
    logic         core_rst;
    logic [W-1:0] stat_rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    rst_ctrl #(.PIN_MIN_CYC(P), .STAB_CYC(S), .RD_W(W)) i_rst_ctrl (
        .clk          (clk),
        .ext_rst_n    (ext_rst_n),
        .supply_good  (supply_good),
        .core_rst     (core_rst),
        .stat_rd_en   (stat_rd_en),
        .stat_rd_data (stat_rd_data)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd_flag(output int v);
        stat_rd_en = 1'b1;
        step();
        stat_rd_en = 1'b0;
        v = int'(stat_rd_data);
    endtask

    task automatic steps_until(input logic val, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (core_rst !== val && n < 300);
    endtask

    // Drop the supply for one cycle, restore it and wait for release.
    task automatic por_cycle(input string req);
        int n;
        supply_good = 1'b0;
        step();
        supply_good = 1'b1;
        steps_until(1'b0, n);
        chk(req, n, S);
    endtask

    initial begin
        int n;
        int v;
        int seen;

        // Reset state: pin high, supply low -> power-on reset and flag set.
        repeat (3) step();
        chk("R4 reset state core_rst", int'(core_rst), 1);
        rd_flag(v);
        chk("R7 R9 flag after power-up", v, 1);

        // R5: release exactly S cycles after the supply turns good.
        supply_good = 1'b1;
        steps_until(1'b0, n);
        chk("R5 stabilisation length", n, S);

        // R4 and R6: dip at every position of the count.
        for (int d = 0; d <= S - 2; d++) begin
            supply_good = 1'b0;
            #1;
            chk("R4 immediate assertion", int'(core_rst), 1);
            step();
            supply_good = 1'b1;
            repeat (d) step();
            chk("R6 still in reset before dip", int'(core_rst), 1);
            supply_good = 1'b0;
            step();
            supply_good = 1'b1;
            steps_until(1'b0, n);
            chk("R6 count restarted", n, S);
        end

        // R2: pulses shorter than P are ignored.
        for (int w = 1; w < P; w++) begin
            seen = 0;
            ext_rst_n = 1'b0;
            repeat (w) begin
                step();
                if (core_rst) seen = 1;
            end
            ext_rst_n = 1'b1;
            repeat (4) begin
                step();
                if (core_rst) seen = 1;
            end
            chk("R2 short pulse no reset", seen, 0);
            rd_flag(v);
            chk("R2 flag unchanged", v, 1);
        end

        // Boundary: a pulse of exactly P cycles is accepted.
        seen = 0;
        ext_rst_n = 1'b0;
        repeat (P) begin
            step();
            if (core_rst) seen = 1;
        end
        ext_rst_n = 1'b1;
        repeat (6) begin
            step();
            if (core_rst) seen = 1;
        end
        chk("R1 boundary pulse accepted", seen, 1);
        chk("R3 released after boundary pulse", int'(core_rst), 0);
        rd_flag(v);
        chk("R8 flag cleared by pin reset", v, 0);
        por_cycle("R5 release after re-power");
        rd_flag(v);
        chk("R7 flag set again", v, 1);

        // R1 and R3: longer pulses, assertion and release timing.
        for (int w = P + 1; w <= P + 4; w++) begin
            ext_rst_n = 1'b0;
            steps_until(1'b1, n);
            chk("R1 assertion delay", n, P + 1);
            repeat (w - (P + 1)) step();
            chk("R1 held while pin low", int'(core_rst), 1);
            ext_rst_n = 1'b1;
            steps_until(1'b0, n);
            chk("R3 release delay", n, 3);
            rd_flag(v);
            chk("R8 flag cleared", v, 0);
            por_cycle("R5 release after re-power");
            rd_flag(v);
            chk("R7 flag set by power-on", v, 1);
        end

        // R8: pin priority over a simultaneous power-on condition.
        supply_good = 1'b0;
        step();
        ext_rst_n = 1'b0;
        repeat (P + 4) step();
        rd_flag(v);
        chk("R8 flag cleared under supply low", v, 0);
        chk("R8 reset held", int'(core_rst), 1);
        ext_rst_n = 1'b1;
        repeat (4) step();
        chk("R8 power-on resumes after pin", int'(core_rst), 1);
        rd_flag(v);
        chk("R7 next power-on event sets flag", v, 1);
        supply_good = 1'b1;
        steps_until(1'b0, n);
        chk("R5 release after priority case", n, S);

        // R9: read register holds while not enabled.
        ext_rst_n = 1'b0;
        repeat (P + 2) step();
        ext_rst_n = 1'b1;
        repeat (5) step();
        chk("R9 read data held", int'(stat_rd_data), 1);
        rd_flag(v);
        chk("R9 fresh read value", v, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule